// File: doc/BRIEF.md
# Clock Source Mode Controller

This block turns the control fields of a clock generator into an operating mode and the gates that go with it. A 2-bit source field, a reference-choice bit, a low-power bit, a debug-active flag and a stop request together pick one of seven modes. The chosen mode sets where the output clock comes from, whether the frequency-locked loop runs, whether the loop-derived debug clock may be used, and which reference clocks stay gated on.

A second part tracks reference switches. The reference-choice bit may change at any time. A status bit takes on the new value only after the loop has had time to relock. That time is measured as a number of pulses of the divided reference, which arrive on a tick input, and the count starts over if the choice changes again before the count ends. All outputs except the status bit are combinational functions of the current inputs.

Top module: `clkmode_ctrl`

## Requirements
- R1: While reset is active and on the first cycle after it, `refst_o` is 1.
- R2: `mode_o` is 0 (engaged-internal) when `refsel_i`=1 and 1 (engaged-external) when `refsel_i`=0, with `outsel_o`=00 (loop output) and `fll_en_o`=1. This applies when `clksel_i` is 00 or 11, when `clksel_i`=01 with `refsel_i`=0, and when `clksel_i`=10 with `refsel_i`=1, each without stop.
- R3: When `clksel_i`=01 and `refsel_i`=1, `outsel_o` is 01 (internal reference). If `lp_i`=1 and `dbg_i`=0, `mode_o` is 3 and `fll_en_o`=0. Otherwise `mode_o` is 2 and `fll_en_o`=1.
- R4: When `clksel_i`=10, `refsel_i`=0 and either `dbg_i`=1 or `lp_i`=0, `mode_o` is 4, `outsel_o` is 10 (external reference) and `fll_en_o`=1.
- R5: When `clksel_i`=10, `refsel_i`=0, `dbg_i`=0 and `lp_i`=1, `mode_o` is 5, `outsel_o` is 10 and `fll_en_o`=0.
- R6: `dbgclk_en_o` equals `fll_en_o` in every mode, so it is 0 in modes 3, 5 and 6.
- R7: Outside stop, `irclk_en_o` is `irc_en_i` OR (mode is 0, 2 or 3), and `erclk_en_o` is `erc_en_i` OR (mode is 1, 4 or 5). Both external bypass modes therefore turn the external reference on even when its enable bit is 0.
- R8: With `stop_i`=1, `mode_o` is 6, `outsel_o` is 11 and `fll_en_o`=0. `irclk_en_o` is `irc_en_i` AND `irc_sten_i`, and `erclk_en_o` is `erc_en_i` AND `erc_sten_i`.
- R9: After `refsel_i` changes, `refst_o` keeps its old value until LOCK_TICKS (default 4) cycles with `tick_i`=1 have passed. It takes the new value at the clock edge of the last of those ticks. A tick in the same cycle as the change is not counted.
- R10: If `refsel_i` changes again before the count ends, the count starts over from zero toward the newest value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clksel_i | input | 2 | Output-clock source field |
| refsel_i | input | 1 | Reference choice: 1 internal, 0 external |
| lp_i | input | 1 | Low-power bit |
| dbg_i | input | 1 | Debug session active |
| stop_i | input | 1 | Stop request |
| irc_en_i | input | 1 | Internal reference enable |
| irc_sten_i | input | 1 | Internal reference enable in stop |
| erc_en_i | input | 1 | External reference enable |
| erc_sten_i | input | 1 | External reference enable in stop |
| tick_i | input | 1 | One-cycle pulse per divided-reference period |
| mode_o | output | 3 | Decoded mode, 0 to 6 |
| outsel_o | output | 2 | Output-clock source: 00 loop, 01 internal, 10 external, 11 none |
| fll_en_o | output | 1 | Frequency-locked loop enable |
| dbgclk_en_o | output | 1 | Loop-derived debug clock available |
| irclk_en_o | output | 1 | Internal reference clock gate |
| erclk_en_o | output | 1 | External reference clock gate |
| refst_o | output | 1 | Reference status after relock |

## Verification
A vector table covers each source-field value with both reference choices. Most of the pairs that do not match fall back to an engaged mode, which separates the fallback path from the bypass decodes. The low-power bit is applied with and without the debug flag in both bypass modes, and this shows whether debug really overrides low power. Stop vectors use enable/stop-enable pairs where only one bit of a pair is set, and a bypass-external setting with no enables, which shows that forced enables do not reach the stop gating. Directed relock sequences count ticks up to the edge of the switch, and a back-and-forth change checks that the count restarts.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

   typedef enum logic [2:0] {
      M_ENG_INT  = 3'd0,
      M_ENG_EXT  = 3'd1,
      M_BYP_INT  = 3'd2,
      M_BYP_INTL = 3'd3,
      M_BYP_EXT  = 3'd4,
      M_BYP_EXTL = 3'd5,
      M_STOP     = 3'd6
   } cmode_e;

   localparam logic [1:0] SRC_FLL  = 2'b00;
   localparam logic [1:0] SRC_IREF = 2'b01;
   localparam logic [1:0] SRC_EREF = 2'b10;
   localparam logic [1:0] SRC_NONE = 2'b11;

   localparam int NREF     = 2;
   localparam int REF_INT  = 0;
   localparam int REF_EXT  = 1;

endpackage

// File: rtl/clkmode_decode.sv
module clkmode_decode
   import clkmode_pkg::*;
#(
   parameter bit DBG_OVERRIDE = 1'b1
) (
   input  logic [1:0] clksel_i,
   input  logic       refsel_i,
   input  logic       lp_i,
   input  logic       dbg_i,
   input  logic       stop_i,
   output cmode_e     mode_o
);

   logic lp_eff;

   generate
      if (DBG_OVERRIDE) begin : g_dbg_ovr
         assign lp_eff = lp_i & ~dbg_i;
      end else begin : g_dbg_plain
         logic unused_dbg;
         assign unused_dbg = dbg_i;
         assign lp_eff     = lp_i;
      end
   endgenerate

   always_comb begin
      if (stop_i) begin
         mode_o = M_STOP;
      end else if (clksel_i == 2'b01 && refsel_i) begin
         mode_o = lp_eff ? M_BYP_INTL : M_BYP_INT;
      end else if (clksel_i == 2'b10 && !refsel_i) begin
         mode_o = lp_eff ? M_BYP_EXTL : M_BYP_EXT;
      end else begin
         mode_o = refsel_i ? M_ENG_INT : M_ENG_EXT;
      end
   end

endmodule

// File: rtl/clkmode_gates.sv
module clkmode_gates
   import clkmode_pkg::*;
(
   input  cmode_e          mode_i,
   input  logic [NREF-1:0] en_i,
   input  logic [NREF-1:0] sten_i,
   output logic [1:0]      outsel_o,
   output logic            fll_en_o,
   output logic            dbgclk_en_o,
   output logic [NREF-1:0] ref_en_o
);

   logic [NREF-1:0] used;
   logic            in_stop;

   assign in_stop = (mode_i == M_STOP);

   always_comb begin
      used = '0;
      unique case (mode_i)
         M_ENG_INT, M_BYP_INT, M_BYP_INTL: used[REF_INT] = 1'b1;
         M_ENG_EXT, M_BYP_EXT, M_BYP_EXTL: used[REF_EXT] = 1'b1;
         default:                          used          = '0;
      endcase
   end

   always_comb begin
      unique case (mode_i)
         M_BYP_INT, M_BYP_INTL: outsel_o = SRC_IREF;
         M_BYP_EXT, M_BYP_EXTL: outsel_o = SRC_EREF;
         M_STOP:                outsel_o = SRC_NONE;
         default:               outsel_o = SRC_FLL;
      endcase
   end

   assign fll_en_o    = !(mode_i inside {M_BYP_INTL, M_BYP_EXTL, M_STOP});
   assign dbgclk_en_o = fll_en_o;

   for (genvar g = 0; g < NREF; g++) begin : g_ref
      assign ref_en_o[g] = in_stop ? (en_i[g] & sten_i[g])
                                   : (en_i[g] | used[g]);
   end

endmodule

// File: rtl/clkmode_relock.sv
module clkmode_relock #(
   parameter int LOCK_TICKS = 4,
   localparam int CW = (LOCK_TICKS > 1) ? $clog2(LOCK_TICKS) : 1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic refsel_i,
   input  logic tick_i,
   output logic refst_o
);

   generate
      if (LOCK_TICKS < 1) begin : g_bad_ticks
         $error("LOCK_TICKS must be at least 1");
      end
   endgenerate

   logic          tgt_q;
   logic          refst_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tgt_q   <= 1'b1;
         refst_q <= 1'b1;
         cnt_q   <= '0;
      end else if (refsel_i != tgt_q) begin
         tgt_q <= refsel_i;
         cnt_q <= '0;
      end else if (tgt_q != refst_q && tick_i) begin
         if (cnt_q == CW'(LOCK_TICKS - 1)) begin
            refst_q <= tgt_q;
            cnt_q   <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign refst_o = refst_q;

   // R9
   refst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i |=> $stable(refst_q));

   // R9
   refst_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(refst_q) |-> $past(refsel_i));

   // R10
   cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(cnt_q) < LOCK_TICKS);

endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
   import clkmode_pkg::*;
#(
   parameter int LOCK_TICKS   = 4,
   parameter bit DBG_OVERRIDE = 1'b1
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [1:0] clksel_i,
   input  logic       refsel_i,
   input  logic       lp_i,
   input  logic       dbg_i,
   input  logic       stop_i,
   input  logic       irc_en_i,
   input  logic       irc_sten_i,
   input  logic       erc_en_i,
   input  logic       erc_sten_i,
   input  logic       tick_i,
   output logic [2:0] mode_o,
   output logic [1:0] outsel_o,
   output logic       fll_en_o,
   output logic       dbgclk_en_o,
   output logic       irclk_en_o,
   output logic       erclk_en_o,
   output logic       refst_o
);

   cmode_e          mode;
   logic [NREF-1:0] en, sten, ref_en;

   assign en[REF_INT]   = irc_en_i;
   assign en[REF_EXT]   = erc_en_i;
   assign sten[REF_INT] = irc_sten_i;
   assign sten[REF_EXT] = erc_sten_i;

   clkmode_decode #(.DBG_OVERRIDE(DBG_OVERRIDE)) u_dec (
      .clksel_i (clksel_i),
      .refsel_i (refsel_i),
      .lp_i     (lp_i),
      .dbg_i    (dbg_i),
      .stop_i   (stop_i),
      .mode_o   (mode)
   );

   clkmode_gates u_gate (
      .mode_i      (mode),
      .en_i        (en),
      .sten_i      (sten),
      .outsel_o    (outsel_o),
      .fll_en_o    (fll_en_o),
      .dbgclk_en_o (dbgclk_en_o),
      .ref_en_o    (ref_en)
   );

   clkmode_relock #(.LOCK_TICKS(LOCK_TICKS)) u_lock (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .refsel_i (refsel_i),
      .tick_i   (tick_i),
      .refst_o  (refst_o)
   );

   assign mode_o     = mode;
   assign irclk_en_o = ref_en[REF_INT];
   assign erclk_en_o = ref_en[REF_EXT];

   // R5
   lp_fll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clksel_i == 2'b10 && !refsel_i && lp_i && !dbg_i && !stop_i) |-> !fll_en_o);

   // R8
   stop_ir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stop_i && !(irc_en_i && irc_sten_i)) |-> !irclk_en_o);

   // R8
   stop_er_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stop_i && !(erc_en_i && erc_sten_i)) |-> !erclk_en_o);

endmodule

// File: tb/sim_clkmode_ctrl.sv
module sim_clkmode_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 16;

   // {clksel, refsel, lp, dbg, stop, irc_en, irc_sten, erc_en, erc_sten} _
   // {mode, outsel, fll_en, dbgclk_en, irclk_en, erclk_en}
   localparam logic [18:0] VEC [NVEC] = '{
      19'b00_1_0_0_0_0000_000_00_1_1_1_0,
      19'b00_0_0_0_0_0000_001_00_1_1_0_1,
      19'b01_1_0_0_0_0000_010_01_1_1_1_0,
      19'b01_1_1_0_0_0000_011_01_0_0_1_0,
      19'b01_1_1_1_0_0000_010_01_1_1_1_0,
      19'b10_0_0_0_0_0000_100_10_1_1_0_1,
      19'b10_0_1_0_0_0000_101_10_0_0_0_1,
      19'b10_0_1_1_0_0000_100_10_1_1_0_1,
      19'b10_0_1_0_0_1000_101_10_0_0_1_1,
      19'b10_1_1_0_0_0000_000_00_1_1_1_0,
      19'b11_0_0_0_0_0000_001_00_1_1_0_1,
      19'b00_1_0_0_1_1110_110_11_0_0_1_0,
      19'b00_1_0_0_1_1011_110_11_0_0_0_1,
      19'b10_0_0_0_1_0000_110_11_0_0_0_0,
      19'b00_1_0_0_0_0010_000_00_1_1_1_1,
      19'b01_0_0_0_0_0000_001_00_1_1_0_1
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] clksel = 2'b00;
   logic       refsel = 1'b1;
   logic       lp = 1'b0, dbg = 1'b0, stp = 1'b0;
   logic       ie = 1'b0, is = 1'b0, ee = 1'b0, es = 1'b0;
   logic       tick = 1'b0;
   logic [2:0] mode;
   logic [1:0] outsel;
   logic       fll_en, dbgclk_en, irclk_en, erclk_en, refst;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   clkmode_ctrl u0 (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .clksel_i    (clksel),
      .refsel_i    (refsel),
      .lp_i        (lp),
      .dbg_i       (dbg),
      .stop_i      (stp),
      .irc_en_i    (ie),
      .irc_sten_i  (is),
      .erc_en_i    (ee),
      .erc_sten_i  (es),
      .tick_i      (tick),
      .mode_o      (mode),
      .outsel_o    (outsel),
      .fll_en_o    (fll_en),
      .dbgclk_en_o (dbgclk_en),
      .irclk_en_o  (irclk_en),
      .erclk_en_o  (erclk_en),
      .refst_o     (refst)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic string mode_req(input logic [2:0] m);
      case (m)
         3'd0, 3'd1: return "R2";
         3'd2, 3'd3: return "R3";
         3'd4:       return "R4";
         3'd5:       return "R5";
         default:    return "R8";
      endcase
   endfunction

   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk) tick = 1'b1;
         @(negedge clk) tick = 1'b0;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 refst in reset", int'(refst), 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 refst after reset", int'(refst), 1);

      for (int v = 0; v < NVEC; v++) begin
         logic [18:0] w;
         string       rq;
         w = VEC[v];
         @(negedge clk);
         {clksel, refsel, lp, dbg, stp, ie, is, ee, es} = w[18:9];
         #1;
         rq = mode_req(w[8:6]);
         chk($sformatf("%s mode v%0d", rq, v), int'(mode), int'(w[8:6]));
         chk($sformatf("%s outsel v%0d", rq, v), int'(outsel), int'(w[5:4]));
         chk($sformatf("%s fll_en v%0d", rq, v), int'(fll_en), int'(w[3]));
         chk($sformatf("R6 dbgclk v%0d", v), int'(dbgclk_en), int'(w[2]));
         chk($sformatf("%s irclk v%0d", stp ? "R8" : "R7", v), int'(irclk_en), int'(w[1]));
         chk($sformatf("%s erclk v%0d", stp ? "R8" : "R7", v), int'(erclk_en), int'(w[0]));
      end

      // settle on internal reference
      @(negedge clk);
      {clksel, lp, dbg, stp, ie, is, ee, es} = '0;
      refsel = 1'b1;
      ticks(4);
      chk("R9 settled internal", int'(refst), 1);

      // switch to external, tick in the same cycle is not counted
      @(negedge clk);
      refsel = 1'b0;
      tick   = 1'b1;
      @(negedge clk) tick = 1'b0;
      chk("R9 change-cycle tick ignored", int'(refst), 1);
      ticks(3);
      chk("R9 before last tick", int'(refst), 1);
      ticks(1);
      chk("R9 after last tick", int'(refst), 0);
      ticks(2);
      chk("R9 stays after extra ticks", int'(refst), 0);

      // restart: go internal, partial count, back, then internal again
      @(negedge clk) refsel = 1'b1;
      ticks(2);
      @(negedge clk) refsel = 1'b0;
      ticks(2);
      chk("R10 return to old choice", int'(refst), 0);
      @(negedge clk) refsel = 1'b1;
      ticks(3);
      chk("R10 count restarted", int'(refst), 0);
      ticks(1);
      chk("R10 new count complete", int'(refst), 1);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule